// File: doc/BRIEF.md
# Ring-Wrapped Paced DMA Channel

This block is one DMA channel that streams a table from memory into a single fixed destination, normally the write port of a FIFO. On each beat it reads one element of 1, 2 or 4 bytes from a byte-addressed memory port. It then presents that element, zero-extended, on a write port whose address never changes. The destination raises a data-request line while its FIFO has room. The channel starts a beat only while that line is high, so the FIFO cannot overflow.

The read address can be confined to a ring. A ring field of k keeps every address bit at or above k fixed and lets only the low k bits advance. A table of 2^k bytes placed on a 2^k boundary is therefore replayed forever without software help. A 32-bit transfer count sets how long the channel runs. Its top four bits are a mode field, and the value all-ones in that field makes the channel endless: the count is never decremented and the channel never finishes, so writing -1 to the count gives an endless loop. In any other mode the low 28 bits count the beats down. The channel stops at zero and gives a one-cycle done pulse.

A configuration write loads the source, destination, count, ring and size all at once. It can start the channel in the same cycle, or leave it loaded and waiting for a separate trigger. A level enable pauses the channel between beats and resumes it from the next address.

Top module: `ring_dma_chan`

## Requirements
- R1: A configuration write with `cfg_trig` high starts the channel at once. With `cfg_trig` low the channel loads but stays idle (`busy` low, no beats) until a one-cycle `trig` pulse starts it.
- R2: The read address starts at `cfg_src` and advances by the element size after every beat. The size code `cfg_size` is 0 for 1 byte and 1 for 2 bytes; 2 or 3 select 4 bytes. Elements are naturally aligned.
- R3: When `cfg_ring` = k is between 1 and 15, address bits k and above stay at their configured value and the low k bits wrap modulo 2^k. k = 0 disables wrapping.
- R4: `wr_addr` equals `cfg_dst` for the whole run. `wr_data` carries the element from byte lanes `addr[1:0]` upward of the memory word, zero-extended to 32 bits.
- R5: A beat begins only if `dreq` and `enable` were high at the previous clock edge. A beat is `mem_req` for one cycle, then `wr_en` for the next cycle. The memory returns the word one cycle after `mem_req`.
- R6: If `cfg_count[31:28]` is 4'hF, the channel is endless: `busy` stays high and `done` never pulses. Any other mode value runs `cfg_count[27:0]` beats.
- R7: In a counted run exactly the programmed number of writes occur. `done` pulses for one cycle in the cycle where `busy` first reads low.
- R8: A triggered configuration with mode other than 4'hF and zero low count performs no beat, leaves `busy` low and gives no `done`.
- R9: While `enable` is low no new beat starts, and a beat already begun still completes. Raising `enable` again continues from the next address without losing or repeating an element.
- R10: A configuration write abandons any beat in progress. With `cfg_trig` low it stops an endless run; no further writes follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load all configuration fields |
| cfg_src | input | AW | Initial read byte address |
| cfg_dst | input | AW | Fixed destination address |
| cfg_count | input | 32 | Mode in [31:28], beat count in [27:0] |
| cfg_ring | input | 4 | Ring size in address bits, 0 = none |
| cfg_size | input | 2 | Element size code |
| cfg_trig | input | 1 | Start immediately on load |
| trig | input | 1 | Start a loaded, idle channel |
| enable | input | 1 | Level; low pauses between beats |
| dreq | input | 1 | Destination has room |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read byte address |
| mem_rdata | input | 32 | Memory word, one cycle after request |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | AW | Destination address |
| wr_data | output | 32 | Element written |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench runs a 70-beat byte stream through a 32-byte ring. A design that carried into the upper address bits would leave the table after entry 31, and the data compare would fail there. A 4-byte run with a 16-byte ring that starts mid-ring catches a wrap implemented as a reset to the configured base: that design would replay from the start offset instead of the ring boundary.

Holding the request low and then toggling it checks that no beat slips through unpaced. Pausing mid-run checks that an element is neither dropped nor repeated. An endless run is checked to keep writing after its expected items drain, and a non-0xF mode is checked to still count. A zero count is checked to produce no beat at all. A design that decremented before testing for zero would wrap to a huge count and never stop.

// File: rtl/ring_dma_chan.sv
module ring_dma_chan #(
  parameter int AW = 16,
  parameter int CW = 28,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [31:0]   cfg_count,
  input  logic [3:0]    cfg_ring,
  input  logic [1:0]    cfg_size,
  input  logic          cfg_trig,
  input  logic          trig,
  input  logic          enable,
  input  logic          dreq,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          busy,
  output logic          done
);
  localparam int CNTW = CW + MW;

  typedef enum logic [1:0] {PH_IDLE, PH_RD, PH_WR} phase_t;

  phase_t        ph;
  logic [AW-1:0] rd_addr, dst_q, mask, next_addr;
  logic [CW-1:0] left_q;
  logic          endless_q, busy_q, done_q;
  logic [3:0]    ring_q;
  logic [1:0]    size_q;
  logic [2:0]    step;
  logic [31:0]   lane;
  logic          last, go, cfg_endless, cfg_nonzero;

  assign step = (size_q == 2'd0) ? 3'd1 : (size_q == 2'd1) ? 3'd2 : 3'd4;
  assign mask = (ring_q == 4'd0 || 32'(ring_q) >= AW) ? '1
              : ((AW'(1) << ring_q) - AW'(1));
  assign next_addr = (rd_addr & ~mask) | ((rd_addr + AW'(step)) & mask);
  assign last = !endless_q && (left_q == CW'(1));
  assign go   = busy_q && enable && dreq;
  assign cfg_endless = (cfg_count[CNTW-1 -: MW] == {MW{1'b1}});
  assign cfg_nonzero = (cfg_count[CW-1:0] != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      rd_addr   <= '0;
      dst_q     <= '0;
      left_q    <= '0;
      endless_q <= 1'b0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      ring_q    <= '0;
      size_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (cfg_we) begin
        rd_addr   <= cfg_src;
        dst_q     <= cfg_dst;
        left_q    <= cfg_count[CW-1:0];
        endless_q <= cfg_endless;
        ring_q    <= cfg_ring;
        size_q    <= cfg_size;
        ph        <= PH_IDLE;
        busy_q    <= cfg_trig && (cfg_endless || cfg_nonzero);
      end else begin
        case (ph)
          PH_IDLE: begin
            if (!busy_q && trig && (endless_q || left_q != '0))
              busy_q <= 1'b1;
            if (go)
              ph <= PH_RD;
          end
          PH_RD: ph <= PH_WR;
          PH_WR: begin
            rd_addr <= next_addr;
            if (!endless_q)
              left_q <= left_q - CW'(1);
            if (last) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
              ph     <= PH_IDLE;
            end else begin
              ph <= (enable && dreq) ? PH_RD : PH_IDLE;
            end
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  assign lane = mem_rdata >> {rd_addr[1:0], 3'b000};

  always_comb begin
    case (size_q)
      2'd0:    wr_data = {24'd0, lane[7:0]};
      2'd1:    wr_data = {16'd0, lane[15:0]};
      default: wr_data = lane;
    endcase
  end

  assign mem_req  = (ph == PH_RD);
  assign mem_addr = rd_addr;
  assign wr_en    = (ph == PH_WR);
  assign wr_addr  = dst_q;
  assign busy     = busy_q;
  assign done     = done_q;
endmodule

// File: rtl/ring_dma_chan_chk.sv
module ring_dma_chan_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          enable,
  input logic          dreq,
  input logic          mem_req,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          busy,
  input logic          done,
  input logic          endless_q
);
  // R5
  beat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !cfg_we |=> wr_en);

  // R5
  paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $past(dreq && enable));

  // R5
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && wr_en));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  endless_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && endless_q && !cfg_we |=> busy);

  // R9
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !mem_req && !wr_en && !cfg_we |=> !mem_req);

  // R4
  dst_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(cfg_we) |-> $stable(wr_addr));
endmodule

bind ring_dma_chan ring_dma_chan_chk #(.AW(AW)) u_chk (.*);

// File: tb/ring_dma_chan_tb.sv
module ring_dma_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_trig = 1'b0, trig = 1'b0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [31:0]   cfg_count = '0;
  logic [3:0]    cfg_ring = '0;
  logic [1:0]    cfg_size = '0;
  logic          enable = 1'b1, dreq = 1'b1;
  logic          mem_req, wr_en, busy, done;
  logic [AW-1:0] mem_addr, wr_addr;
  logic [31:0]   mem_rdata = '0, wr_data;

  logic [7:0]    mem [1024];
  logic [31:0]   q [$];
  logic [AW-1:0] exp_dst = '0;
  int nchk = 0, nfail = 0, wcount = 0, extra = 0, dones = 0, cyc = 0;

  ring_dma_chan #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_count(cfg_count), .cfg_ring(cfg_ring),
    .cfg_size(cfg_size), .cfg_trig(cfg_trig), .trig(trig),
    .enable(enable), .dreq(dreq), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 37 + (i >> 8) * 11 + 5);

  always @(posedge clk)
    if (mem_req) begin
      int b;
      b = {22'd0, mem_addr[9:2], 2'b00};
      mem_rdata <= {mem[b+3], mem[b+2], mem[b+1], mem[b]};
    end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] elem(input logic [AW-1:0] a, input int size);
    int b;
    b = {22'd0, a[9:0]};
    if (size == 0) return {24'd0, mem[b]};
    if (size == 1) return {16'd0, mem[b+1], mem[b]};
    return {mem[b+3], mem[b+2], mem[b+1], mem[b]};
  endfunction

  // driver: expected element sequence from R2/R3
  task automatic push_run(input logic [AW-1:0] base, input int n,
                          input int ring, input int size);
    logic [AW-1:0] m, a;
    int step;
    step = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    m = (ring == 0) ? '1 : AW'((1 << ring) - 1);
    for (int i = 0; i < n; i++) begin
      a = (base & ~m) | ((base + AW'(step * i)) & m);
      q.push_back(elem(a, size));
    end
  endtask

  task automatic cfg(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                     input logic [31:0] cnt, input int ring, input int size,
                     input bit t);
    @(negedge clk);
    cfg_src = src; cfg_dst = dst; cfg_count = cnt;
    cfg_ring = 4'(ring); cfg_size = 2'(size); cfg_trig = t; cfg_we = 1'b1;
    exp_dst = dst;
    @(negedge clk);
    cfg_we = 1'b0; cfg_trig = 1'b0;
  endtask

  task automatic wait_drain(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (q.size() == 0 && !busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // monitor: pops expected items as writes appear
  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      wcount++;
      if (q.size() > 0) begin
        logic [31:0] e;
        e = q.pop_front();
        chk(wr_data == e, "R2/R3", "element data", wr_data, e);
        chk(wr_addr == exp_dst, "R4", "fixed destination", 32'(wr_addr), 32'(exp_dst));
      end else extra++;
    end
    if (done) begin
      dones++;
      chk(!busy, "R7", "busy low with done", 32'(busy), 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int d0, w0;
    logic [15:0] lfsr;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req && !wr_en && !done, "R1", "reset idle",
        {28'd0, busy, mem_req, wr_en, done}, 0);

    // R2 R3: byte stream through a 32-byte ring
    push_run(16'h0100, 70, 5, 0);
    d0 = dones;
    cfg(16'h0100, 16'hA000, 32'd70, 5, 0, 1'b1);
    wait_drain(1000);
    chk(q.size() == 0 && extra == 0, "R7", "all 70 written, no extra", 32'(extra), 0);
    chk(dones == d0 + 1, "R7", "single done", 32'(dones - d0), 1);

    // R2: 2-byte elements, no ring
    push_run(16'h0040, 10, 0, 1);
    cfg(16'h0040, 16'hA010, 32'd10, 0, 1, 1'b1);
    wait_drain(500);
    chk(q.size() == 0, "R2", "halfword run drained", 32'(q.size()), 0);

    // R3: 4-byte elements, 16-byte ring, start mid-ring
    push_run(16'h0088, 8, 4, 2);
    cfg(16'h0088, 16'hA020, 32'd8, 4, 2, 1'b1);
    wait_drain(500);
    chk(q.size() == 0, "R3", "word ring drained", 32'(q.size()), 0);

    // R1: load without trigger, then trig pulse
    push_run(16'h0200, 4, 0, 1);
    w0 = wcount;
    cfg(16'h0200, 16'hA030, 32'd4, 0, 1, 1'b0);
    repeat (10) @(negedge clk);
    chk(!busy && wcount == w0, "R1", "idle before trig", 32'(wcount - w0), 0);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    wait_drain(200);
    chk(wcount == w0 + 4, "R1", "writes after trig", 32'(wcount - w0), 4);

    // R5: pacing
    dreq = 1'b0;
    push_run(16'h0300, 8, 5, 0);
    w0 = wcount;
    cfg(16'h0300, 16'hA040, 32'd8, 5, 0, 1'b1);
    repeat (30) @(negedge clk);
    chk(busy && wcount == w0, "R5", "no beat without dreq", 32'(wcount - w0), 0);
    lfsr = 16'hACE1;
    for (int i = 0; i < 400 && (q.size() > 0 || busy); i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dreq = lfsr[0];
      @(negedge clk);
    end
    dreq = 1'b1;
    wait_drain(100);
    chk(q.size() == 0 && wcount == w0 + 8, "R5", "paced run complete", 32'(wcount - w0), 8);

    // R9: pause and resume
    push_run(16'h0120, 40, 5, 0);
    d0 = dones;
    cfg(16'h0120, 16'hA050, 32'd40, 5, 0, 1'b1);
    repeat (21) @(negedge clk);
    enable = 1'b0;
    repeat (4) @(negedge clk);
    w0 = wcount;
    repeat (20) @(negedge clk);
    chk(busy && wcount == w0, "R9", "no beats while paused", 32'(wcount - w0), 0);
    enable = 1'b1;
    wait_drain(500);
    chk(q.size() == 0 && extra == 0 && dones == d0 + 1, "R9", "resume without loss",
        32'(q.size()), 0);

    // R6: endless via all-ones count
    push_run(16'h0340, 100, 5, 0);
    d0 = dones;
    cfg(16'h0340, 16'hA060, 32'hFFFF_FFFF, 5, 0, 1'b1);
    for (int i = 0; i < 2000 && q.size() > 0; i++) @(negedge clk);
    extra = 0;
    repeat (30) @(negedge clk);
    chk(extra > 0 && busy, "R6", "endless keeps running", 32'(extra), 1);
    chk(dones == d0, "R6", "endless never done", 32'(dones - d0), 0);

    // R10: config write stops the endless run
    cfg(16'h0000, 16'hA070, 32'd0, 0, 0, 1'b0);
    @(negedge clk);
    extra = 0;
    repeat (10) @(negedge clk);
    chk(extra == 0 && !busy, "R10", "stopped by reload", 32'(extra), 0);

    // R6: other mode value still counts
    push_run(16'h0060, 3, 0, 0);
    d0 = dones;
    cfg(16'h0060, 16'hA080, 32'h3000_0003, 0, 0, 1'b1);
    wait_drain(200);
    chk(q.size() == 0 && extra == 0 && dones == d0 + 1, "R6", "mode 3 counts",
        32'(dones - d0), 1);

    // R8: zero count
    w0 = wcount; d0 = dones;
    cfg(16'h0060, 16'hA090, 32'd0, 0, 0, 1'b1);
    repeat (10) @(negedge clk);
    chk(!busy && wcount == w0 && dones == d0, "R8", "zero count idle",
        32'(wcount - w0), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule